// File: doc/BRIEF.md
# CCD Frame and Exposure Controller

This block sequences whole frames for a frame-transfer CCD sensor. Each accepted frame request runs an optional electronic-shutter interval, an integration interval, a guarded image-to-memory transfer and then the readout of every memory line through external vertical and horizontal line sequencers. During the shutter interval the block holds all image-zone phases low, so photo-charge drains away through the antiblooming structure. Integration begins when the phases are released.

The exposure engine and the readout engine are separate. After a transfer hands a frame to the memory zone, the exposure engine is free to shutter and integrate the next frame while the memory is still being read. The next transfer is held back until the memory is empty, which lengthens integration. This is also how a lower frame rate is obtained. In binning mode, two memory lines are merged into the output register for each horizontal readout.

The sub-sequencers are started by one-cycle command pulses and answer with one-cycle completion pulses. Shutter and integration lengths are counted in system-clock cycles.

Top module: `ccd_frame_ctrl`

## Requirements
- R1: After reset, ab_gate is 1, and img_hold, vxfer_go, mline_go, hline_go, exp_busy, rd_busy and frame_done are all 0.
- R2: img_hold is 1 for exactly shut_len cycles, starting with the cycle after an accepted request. A shut_len of 0 leaves img_hold at 0. ab_gate is 1 whenever img_hold is 1.
- R3: Once the shutter releases, ab_gate stays 1 for integ_len cycles before it falls, as long as the memory is free. An integ_len of 0 counts as 1. Lengths and bin_mode are sampled when a request is accepted.
- R4: ab_gate falls GUARD cycles before the single-cycle vxfer_go pulse. It stays 0 through the transfer and for GUARD cycles after the cycle in which vxfer_done is 1.
- R5: With bin_mode 0, a frame issues NLINES mline_go pulses. Each pulse is followed, after its mline_done, by one hline_go pulse.
- R6: With bin_mode 1, a frame issues NLINES/2 hline_go pulses. Each is preceded by two mline_go pulses, for NLINES mline_go pulses in total.
- R7: frame_done is a one-cycle pulse. It comes in the cycle after the hline_done of the frame's last line, and rd_busy is 0 in that cycle.
- R8: The shutter and integration of the next frame may run while rd_busy is 1. vxfer_go is never 1 while rd_busy is 1.
- R9: A frame_req that arrives while the exposure engine is busy is queued. At most one request is queued, and further requests are dropped.
- R10: vxfer_done, mline_done and hline_done are ignored outside the states that wait for them. They then cause no command pulse, no frame_done and no busy flag.
- R11: vxfer_go, mline_go and hline_go are single-cycle pulses, and no two of them are 1 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_req | input | 1 | Request one frame |
| shut_len | input | CW | Shutter cycles, 0 disables |
| integ_len | input | CW | Integration cycles |
| bin_mode | input | 1 | Merge two lines per readout |
| img_hold | output | 1 | Hold image phases low (shutter) |
| ab_gate | output | 1 | Antiblooming gate level |
| vxfer_go | output | 1 | Start image-to-memory transfer |
| vxfer_done | input | 1 | Transfer complete |
| mline_go | output | 1 | Shift one memory line into the register |
| mline_done | input | 1 | Memory line shift complete |
| hline_go | output | 1 | Read out the horizontal register |
| hline_done | input | 1 | Horizontal readout complete |
| exp_busy | output | 1 | Exposure engine active |
| rd_busy | output | 1 | Memory readout active |
| frame_done | output | 1 | Last line of a frame read |

## Verification
The assertions check every cycle that ab_gate is low around each transfer pulse and high under the shutter, that no transfer starts while the memory is being read, and that command pulses are single-cycle and mutually exclusive. Interval lengths cannot be seen in a single cycle, so the bench's scenarios measure them: shutter, integration, the guard margins on both sides of the transfer, and the line counts in normal and binning modes. The bench scenarios also cover request queuing with dropping, overlap of the next exposure with readout, and spurious completion pulses.

// File: rtl/ccd_frame_ctrl.sv
module ccd_frame_ctrl #(
  parameter int CW     = 20,
  parameter int NLINES = 1044,
  parameter int GUARD  = 50
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          frame_req,
  input  logic [CW-1:0] shut_len,
  input  logic [CW-1:0] integ_len,
  input  logic          bin_mode,
  output logic          img_hold,
  output logic          ab_gate,
  output logic          vxfer_go,
  input  logic          vxfer_done,
  output logic          mline_go,
  input  logic          mline_done,
  output logic          hline_go,
  input  logic          hline_done,
  output logic          exp_busy,
  output logic          rd_busy,
  output logic          frame_done
);
  localparam int LW = $clog2(NLINES);
  localparam logic [CW-1:0] GLOAD = CW'(GUARD - 1);
  localparam logic [LW-1:0] LAST_N = LW'(NLINES - 1);
  localparam logic [LW-1:0] LAST_B = LW'(NLINES / 2 - 1);

  typedef enum logic [2:0] {E_IDLE, E_SHUT, E_INT, E_WAIT, E_PRE, E_XFER, E_POST} exp_t;
  typedef enum logic [1:0] {R_IDLE, R_MV, R_HZ} rd_t;

  exp_t          e_state;
  rd_t           r_state;
  logic [CW-1:0] cnt, int_q;
  logic          bin_e, bin_r, pend, sub;
  logic [LW-1:0] lcnt;

  wire accept   = (e_state == E_IDLE) && (frame_req || pend);
  wire rd_start = (e_state == E_POST) && (cnt == '0);
  wire [CW-1:0] int_ld = (integ_len == '0) ? '0 : integ_len - 1'b1;
  wire [CW-1:0] int_q_ld = (int_q == '0) ? '0 : int_q - 1'b1;
  wire last_line = lcnt == (bin_r ? LAST_B : LAST_N);

  assign img_hold = (e_state == E_SHUT);
  assign ab_gate  = !(e_state == E_PRE || e_state == E_XFER || e_state == E_POST);
  assign exp_busy = (e_state != E_IDLE);
  assign rd_busy  = (r_state != R_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend <= 1'b0;
    else        pend <= (pend && !accept) || (frame_req && !(accept && !pend));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      e_state  <= E_IDLE;
      cnt      <= '0;
      int_q    <= '0;
      bin_e    <= 1'b0;
      vxfer_go <= 1'b0;
    end else begin
      vxfer_go <= 1'b0;
      case (e_state)
        E_IDLE: if (accept) begin
          int_q <= integ_len;
          bin_e <= bin_mode;
          if (shut_len != '0) begin
            e_state <= E_SHUT;
            cnt     <= shut_len - 1'b1;
          end else begin
            e_state <= E_INT;
            cnt     <= int_ld;
          end
        end
        E_SHUT: if (cnt == '0) begin
          e_state <= E_INT;
          cnt     <= int_q_ld;
        end else cnt <= cnt - 1'b1;
        E_INT: if (cnt == '0) begin
          if (rd_busy) e_state <= E_WAIT;
          else begin
            e_state <= E_PRE;
            cnt     <= GLOAD;
          end
        end else cnt <= cnt - 1'b1;
        E_WAIT: if (!rd_busy) begin
          e_state <= E_PRE;
          cnt     <= GLOAD;
        end
        E_PRE: if (cnt == '0) begin
          e_state  <= E_XFER;
          vxfer_go <= 1'b1;
        end else cnt <= cnt - 1'b1;
        E_XFER: if (vxfer_done && !vxfer_go) begin
          e_state <= E_POST;
          cnt     <= GLOAD;
        end
        E_POST: if (cnt == '0) e_state <= E_IDLE;
                else cnt <= cnt - 1'b1;
        default: e_state <= E_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      r_state    <= R_IDLE;
      lcnt       <= '0;
      sub        <= 1'b0;
      bin_r      <= 1'b0;
      mline_go   <= 1'b0;
      hline_go   <= 1'b0;
      frame_done <= 1'b0;
    end else begin
      mline_go   <= 1'b0;
      hline_go   <= 1'b0;
      frame_done <= 1'b0;
      case (r_state)
        R_IDLE: if (rd_start) begin
          r_state  <= R_MV;
          bin_r    <= bin_e;
          lcnt     <= '0;
          sub      <= 1'b0;
          mline_go <= 1'b1;
        end
        R_MV: if (mline_done && !mline_go) begin
          if (bin_r && !sub) begin
            sub      <= 1'b1;
            mline_go <= 1'b1;
          end else begin
            r_state  <= R_HZ;
            hline_go <= 1'b1;
          end
        end
        R_HZ: if (hline_done && !hline_go) begin
          if (last_line) begin
            r_state    <= R_IDLE;
            frame_done <= 1'b1;
          end else begin
            r_state  <= R_MV;
            lcnt     <= lcnt + 1'b1;
            sub      <= 1'b0;
            mline_go <= 1'b1;
          end
        end
        default: r_state <= R_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ccd_frame_ctrl_chk.sv
module ccd_frame_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic img_hold,
  input logic ab_gate,
  input logic vxfer_go,
  input logic mline_go,
  input logic hline_go,
  input logic exp_busy,
  input logic rd_busy,
  input logic frame_done
);
  // R2
  hold_ab_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    img_hold |-> (ab_gate && exp_busy));
  // R4
  ab_low_at_xfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vxfer_go |-> !ab_gate);
  // R8
  mem_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vxfer_go |-> !rd_busy);
  // R11
  go_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({vxfer_go, mline_go, hline_go}));
  // R11
  go_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vxfer_go || mline_go || hline_go) |=> !(vxfer_go || mline_go || hline_go));
  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> (!rd_busy ##1 !frame_done));
endmodule

bind ccd_frame_ctrl ccd_frame_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .img_hold(img_hold), .ab_gate(ab_gate),
  .vxfer_go(vxfer_go), .mline_go(mline_go), .hline_go(hline_go),
  .exp_busy(exp_busy), .rd_busy(rd_busy), .frame_done(frame_done)
);

// File: tb/ccd_frame_ctrl_test.sv
`timescale 1ns/1ps
module ccd_frame_ctrl_test;
  localparam int CW = 8, N = 6, G = 3;

  logic clk = 0, rst_n = 0, frame_req = 0, bin_mode = 0;
  logic [CW-1:0] shut_len = 0, integ_len = 0;
  logic img_hold, ab_gate, vxfer_go, mline_go, hline_go, exp_busy, rd_busy, frame_done;
  logic vx_m = 0, ml_m = 0, hl_m = 0, vx_s = 0, ml_s = 0, hl_s = 0;
  wire vxfer_done = vx_m | vx_s;
  wire mline_done = ml_m | ml_s;
  wire hline_done = hl_m | hl_s;

  ccd_frame_ctrl #(.CW(CW), .NLINES(N), .GUARD(G)) uut (
    .clk(clk), .rst_n(rst_n), .frame_req(frame_req), .shut_len(shut_len),
    .integ_len(integ_len), .bin_mode(bin_mode), .img_hold(img_hold),
    .ab_gate(ab_gate), .vxfer_go(vxfer_go), .vxfer_done(vxfer_done),
    .mline_go(mline_go), .mline_done(mline_done), .hline_go(hline_go),
    .hline_done(hline_done), .exp_busy(exp_busy), .rd_busy(rd_busy),
    .frame_done(frame_done));

  always #10 clk = ~clk;

  initial forever begin
    @(negedge clk);
    if (vxfer_go) begin repeat (2) @(posedge clk); #1 vx_m = 1; @(posedge clk); #1 vx_m = 0; end
  end
  initial forever begin
    @(negedge clk);
    if (mline_go) begin repeat (2) @(posedge clk); #1 ml_m = 1; @(posedge clk); #1 ml_m = 0; end
  end
  initial forever begin
    @(negedge clk);
    if (hline_go) begin @(posedge clk); #1 hl_m = 1; @(posedge clk); #1 hl_m = 0; end
  end

  int checks = 0, fails = 0;
  int hold_c, int_c, pre_c, post_c, mgo_c, hgo_c, fd_c, vx_c, ovl_c, bad_c, spur_c;
  logic armed, ab_fell, vx_seen, post_f;

  task automatic clr();
    hold_c = 0; int_c = 0; pre_c = 0; post_c = 0; mgo_c = 0; hgo_c = 0;
    fd_c = 0; vx_c = 0; ovl_c = 0; bad_c = 0; spur_c = 0;
    armed = 0; ab_fell = 0; vx_seen = 0; post_f = 0;
  endtask

  always @(negedge clk) begin
    if (img_hold) hold_c++;
    if (armed && ab_gate && !img_hold && !ab_fell) int_c++;
    if (!ab_gate) ab_fell = 1;
    if (armed && !ab_gate && !vx_seen && !vxfer_go) pre_c++;
    if (post_f && !ab_gate) post_c++;
    if (armed && vxfer_done) post_f = 1;
    if (vxfer_go) begin vx_seen = 1; vx_c++; end
    if (mline_go) mgo_c++;
    if (hline_go) hgo_c++;
    if (frame_done) begin fd_c++; if (rd_busy) bad_c++; end
    if (img_hold && rd_busy) ovl_c++;
    if (vxfer_go && rd_busy) bad_c++;
    if (vxfer_go || mline_go || hline_go || frame_done || exp_busy || rd_busy) spur_c++;
  end

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  task automatic request();
    @(posedge clk); #1 frame_req = 1;
    @(posedge clk); #1 frame_req = 0;
  endtask

  task automatic wait_frames(int n, int limit);
    for (int i = 0; i < limit && fd_c < n; i++) @(posedge clk);
    repeat (5) @(posedge clk);
  endtask

  localparam int VEC [5][3] = '{'{3, 5, 0}, '{0, 4, 0}, '{2, 0, 1}, '{5, 1, 1}, '{1, 7, 0}};

  initial begin
    clr();
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 ab_gate", ab_gate, 1);
    chk("R1 outputs", {img_hold, vxfer_go, mline_go, hline_go, exp_busy, rd_busy, frame_done}, 0);
    @(posedge clk); #1 rst_n = 1;
    repeat (3) @(posedge clk);

    for (int v = 0; v < 5; v++) begin
      shut_len = CW'(VEC[v][0]); integ_len = CW'(VEC[v][1]); bin_mode = VEC[v][2][0];
      clr();
      request();
      armed = 1;
      wait_frames(1, 3000);
      chk("R2 shutter length", hold_c, VEC[v][0]);
      chk("R3 integration length", int_c, (VEC[v][1] == 0) ? 1 : VEC[v][1]);
      chk("R4 pre guard", pre_c, G);
      chk("R4 post guard", post_c, G);
      chk("R4 one transfer", vx_c, 1);
      chk(VEC[v][2] ? "R6 mline count" : "R5 mline count", mgo_c, N);
      chk(VEC[v][2] ? "R6 hline count" : "R5 hline count", hgo_c, VEC[v][2] ? N / 2 : N);
      chk("R7 frame_done once", fd_c, 1);
      chk("R8 R7 no transfer in readout", bad_c, 0);
    end

    // R9 queue depth one, R8 overlap of next exposure with readout
    shut_len = 2; integ_len = 6; bin_mode = 0;
    clr();
    request();
    repeat (3) @(posedge clk);
    request();
    repeat (2) @(posedge clk);
    request();
    wait_frames(2, 3000);
    repeat (300) @(posedge clk);
    chk("R9 queued frames", fd_c, 2);
    chk("R9 transfers", vx_c, 2);
    chk("R8 shutter during readout", ovl_c > 0, 1);
    chk("R8 transfer exclusion", bad_c, 0);

    // R10 stray completions while idle
    clr();
    @(posedge clk); #1 vx_s = 1; ml_s = 1; hl_s = 1;
    @(posedge clk); #1 vx_s = 0; ml_s = 0; hl_s = 0;
    repeat (5) @(posedge clk);
    chk("R10 idle ignores done", spur_c, 0);
    shut_len = 1; integ_len = 3; bin_mode = 0;
    clr();
    request();
    armed = 1;
    wait_frames(1, 3000);
    chk("R10 following frame mlines", mgo_c, N);
    chk("R10 following frame hlines", hgo_c, N);
    chk("R10 following frame done", fd_c, 1);
    summary();
  end

  initial begin
    #(200000 * 20);
    fails++;
    $display("FAIL watchdog: actual hung expected finish");
    summary();
  end
endmodule